// File: doc/BRIEF.md
# Trigger-Latency Window Event Extractor

This block sits behind a front-end time digitiser. Every clock cycle it may receive one 16-bit hit word with its 16-bit charge word. The arrival cycle acts as the time stamp. Every cycle, present or not, is written into a circular latency store.

When a level-1 trigger arrives, the block reaches back into that store by a programmable latency L. It then gathers every hit that arrived inside a programmable window of W cycles. The gathered hits are packed into a fixed 17-word event frame in a small multi-frame event buffer. The frame is then handed word by word to a serial transmitter over a valid/ready interface.

Triggers are accepted while the buffer has a free frame slot. A trigger that arrives while all slots are taken is dropped and counted. Latency and window values are loaded through a small control-write port. A new value is held back until no event is waiting or being assembled.

Top module: `trig_window_extractor`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `lost_count` are all zero.
- R2: A frame for a trigger sampled in cycle T holds exactly the hits whose `hit_valid` was sampled in cycles T-L through T-L+W-1, in arrival order. Each hit occupies two words: the hit word at odd position 2n+1 and its charge word at position 2n+2.
- R3: Every frame is 17 words long. Word 0 is the header: bits 15:8 are a trigger tag, bits 3:0 are the number of stored hits, and bits 7:4 are zero. The tag starts at 0 after reset and rises by one for each accepted trigger. Data words that are not used read as zero.
- R4: At most 8 hits are stored per frame. Further hits in the window are discarded, and the header count reads 8.
- R5: With W=0 the frame has a count of 0 and 16 zero data words. With L=0, a hit sampled in the same cycle as the trigger is the first one captured.
- R6: Triggers as close as 5 cycles apart each yield a complete frame, and a hit that lies in two windows appears in both frames.
- R7: `busy` is high exactly when 4 accepted frames have not yet been fully read out. A trigger sampled while `busy` is high creates no frame, consumes no tag and increments `lost_count`.
- R8: The word index advances only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_last` is high on word 16. `tx_data` holds still while the transmitter stalls.
- R9: A control write with `cfg_sel`=0 loads the latency (6 bits). A write with `cfg_sel`=1 loads the window (low 5 bits). Both reset to 20.
- R10: A control write made while a frame is waiting or being assembled does not affect that frame. It applies once the block is idle.
- R11: The window may extend past the trigger cycle (W > L). Hits that arrive after the trigger are then captured too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_word | input | 16 | Time/hit data word |
| charge_word | input | 16 | Charge word paired with the hit |
| trig_in | input | 1 | Level-1 trigger, one cycle per trigger |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0 selects latency, 1 selects window |
| cfg_wdata | input | 6 | Control write value |
| busy | output | 1 | All frame slots are in use |
| lost_count | output | 16 | Saturating count of dropped triggers |
| tx_ready | input | 1 | Transmitter accepts a word |
| tx_valid | output | 1 | A frame word is offered |
| tx_data | output | 16 | Frame word |
| tx_last | output | 1 | Offered word is the last of its frame |

## Verification
The bench uses the default parameters: a 256-entry latency store, 4 frame slots, 8 hits per frame, a 6-bit latency and a 5-bit window. With only four slots, a burst of six triggers against a stalled transmitter reaches the busy state and the lost count. An 8-hit cap is easily exceeded by a 20-cycle window of dense hits. The narrow fields let the bench sweep latency from 0 to 40 and window from 0 to 31. This covers windows reaching past the trigger cycle, while the worst-case lookback stays well inside the store.

// File: rtl/evx_pkg.sv
// Shared types for the trigger window extractor.
package evx_pkg;
    localparam int HIT_W = 16;

    // One latency-store entry: presence flag plus the two data words
    typedef struct packed {
        logic             vld;
        logic [HIT_W-1:0] hit;
        logic [HIT_W-1:0] chg;
    } ring_entry_t;

    // Life cycle of an event-buffer slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/evx_latency_ring.sv
// Circular latency store. Each cycle writes one entry at the current time stamp,
// present or not, so the address of an entry equals its arrival time modulo
// the depth. Assumes readers never look back further than DEPTH-1 cycles.
module evx_latency_ring
    import evx_pkg::*;
#(
    parameter int DEPTH_LOG = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_vld,
    input  logic [HIT_W-1:0]     wr_hit,
    input  logic [HIT_W-1:0]     wr_chg,
    input  logic [DEPTH_LOG-1:0] rd_addr,
    output logic [DEPTH_LOG-1:0] now_ts,
    output ring_entry_t          rd_entry
);
    localparam int DEPTH = 1 << DEPTH_LOG;

    logic [DEPTH_LOG-1:0] now_q;
    logic [DEPTH-1:0]     vld_q;
    logic [HIT_W-1:0]     hit_mem [DEPTH];
    logic [HIT_W-1:0]     chg_mem [DEPTH];

    // Time stamp and presence flags; flags cleared so stale entries never match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
            vld_q <= '0;
        end else begin
            now_q        <= now_q + 1'b1;
            vld_q[now_q] <= wr_vld;
        end
    end

    // Data words, no reset needed: guarded by the presence flag
    always_ff @(posedge clk) begin
        hit_mem[now_q] <= wr_hit;
        chg_mem[now_q] <= wr_chg;
    end

    assign now_ts       = now_q;
    assign rd_entry.vld = vld_q[rd_addr];
    assign rd_entry.hit = hit_mem[rd_addr];
    assign rd_entry.chg = chg_mem[rd_addr];
endmodule

// File: rtl/evx_cfg_regs.sv
// Latency and window registers. Writes land in shadow registers. The active copy
// follows the shadow only on cycles the assembler marks as idle, so a frame in
// flight always sees one consistent setting.
module evx_cfg_regs #(
    parameter int LAT_W   = 6,
    parameter int WIN_W   = 5,
    parameter int CFG_W   = 6,
    parameter int LAT_RST = 20,
    parameter int WIN_RST = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             apply_ok,
    output logic [LAT_W-1:0] act_lat,
    output logic [WIN_W-1:0] act_win
);
    logic [LAT_W-1:0] sh_lat;
    logic [WIN_W-1:0] sh_win;

    // Capture control writes into the shadow copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lat <= LAT_W'(LAT_RST);
            sh_win <= WIN_W'(WIN_RST);
        end else if (cfg_we) begin
            if (cfg_sel) sh_win <= cfg_wdata[WIN_W-1:0];
            else         sh_lat <= cfg_wdata[LAT_W-1:0];
        end
    end

    // Move shadow to active only while nothing is waiting or assembling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lat <= LAT_W'(LAT_RST);
            act_win <= WIN_W'(WIN_RST);
        end else if (apply_ok) begin
            act_lat <= sh_lat;
            act_win <= sh_win;
        end
    end

    // R10
    // cfg_hold_chk
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_ok |=> $stable(act_lat) && $stable(act_win));
endmodule

// File: rtl/evx_frame_asm.sv
// Event buffer with slot allocation, window scan engine and frame readout.
// A trigger claims a slot at once and records its look-back start stamp. The
// scan engine serves waiting slots in order, one store entry per cycle. The
// readout side streams finished slots. Assumes L + NFRAMES*(W+2) + 2 < store depth.
module evx_frame_asm
    import evx_pkg::*;
#(
    parameter int NFRAMES   = 4,
    parameter int MAX_HITS  = 8,
    parameter int DEPTH_LOG = 8,
    parameter int LAT_W     = 6,
    parameter int WIN_W     = 5,
    parameter int TAG_W     = 8,
    parameter int LOST_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_in,
    input  logic [DEPTH_LOG-1:0] now_ts,
    input  logic [LAT_W-1:0]     act_lat,
    input  logic [WIN_W-1:0]     act_win,
    input  ring_entry_t          rd_entry,
    output logic [DEPTH_LOG-1:0] rd_addr,
    output logic                 apply_ok,
    output logic                 busy,
    output logic [LOST_W-1:0]    lost_count,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [HIT_W-1:0]     tx_data,
    output logic                 tx_last
);
    localparam int FRAME_WORDS = 2 * MAX_HITS + 1;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int SLOT_W      = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;
    localparam int CNT_W       = $clog2(NFRAMES + 1);
    localparam int HC_W        = $clog2(MAX_HITS + 1);
    localparam int PAD_W       = HIT_W - TAG_W - HC_W;

    slot_state_e          slot_st    [NFRAMES];
    logic [DEPTH_LOG-1:0] slot_start [NFRAMES];
    logic [TAG_W-1:0]     slot_tag   [NFRAMES];
    logic [HIT_W-1:0]     frame_q    [NFRAMES][FRAME_WORDS];

    logic [SLOT_W-1:0]    alloc_p, proc_p, rd_p;
    logic [CNT_W-1:0]     used_q;
    logic [TAG_W-1:0]     tag_q;
    logic [LOST_W-1:0]    lost_q;
    logic                 eng_act;
    logic [WIN_W:0]       k_q;
    logic [DEPTH_LOG-1:0] ptr_q;
    logic [HC_W-1:0]      hcnt_q;
    logic [IDX_W-1:0]     rd_idx;
    logic [IDX_W-1:0]     hit_idx;

    logic full, accept, start_job, scan_done, store_hit, hshake, pop, any_pend;

    function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(NFRAMES - 1)) ? '0 : p + 1'b1;
    endfunction

    // Handshake and control decodes
    always_comb begin
        full      = (used_q == CNT_W'(NFRAMES));
        accept    = trig_in && !full;
        start_job = !eng_act && (slot_st[proc_p] == SLOT_PEND);
        scan_done = eng_act && (k_q >= {1'b0, act_win});
        store_hit = eng_act && !scan_done && rd_entry.vld && (hcnt_q < HC_W'(MAX_HITS));
        tx_valid  = (slot_st[rd_p] == SLOT_DONE);
        tx_last   = (rd_idx == IDX_W'(FRAME_WORDS - 1));
        hshake    = tx_valid && tx_ready;
        pop       = hshake && tx_last;
        hit_idx   = IDX_W'(2 * hcnt_q + 1);
    end

    // Any slot still waiting for the scan engine
    always_comb begin
        any_pend = 1'b0;
        for (int s = 0; s < NFRAMES; s++)
            if (slot_st[s] == SLOT_PEND) any_pend = 1'b1;
    end

    // Slot life cycle: free -> waiting -> done -> free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NFRAMES; s++) slot_st[s] <= SLOT_FREE;
        end else begin
            if (accept)    slot_st[alloc_p] <= SLOT_PEND;
            if (scan_done) slot_st[proc_p]  <= SLOT_DONE;
            if (pop)       slot_st[rd_p]    <= SLOT_FREE;
        end
    end

    // Per-slot look-back start stamp and trigger tag
    always_ff @(posedge clk) begin
        if (accept) begin
            slot_start[alloc_p] <= now_ts - DEPTH_LOG'(act_lat);
            slot_tag[alloc_p]   <= tag_q;
        end
    end

    // Allocation pointer, tag counter, occupancy and lost-trigger counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_p <= '0;
            tag_q   <= '0;
            used_q  <= '0;
            lost_q  <= '0;
        end else begin
            if (accept) begin
                alloc_p <= nxt(alloc_p);
                tag_q   <= tag_q + 1'b1;
            end
            used_q <= used_q + CNT_W'(accept) - CNT_W'(pop);
            if (trig_in && full && (lost_q != '1)) lost_q <= lost_q + 1'b1;
        end
    end

    // Scan engine: walk W store entries from the slot's start stamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_act <= 1'b0;
            proc_p  <= '0;
            k_q     <= '0;
            ptr_q   <= '0;
            hcnt_q  <= '0;
        end else if (start_job) begin
            eng_act <= 1'b1;
            ptr_q   <= slot_start[proc_p];
            k_q     <= '0;
            hcnt_q  <= '0;
        end else if (scan_done) begin
            eng_act <= 1'b0;
            proc_p  <= nxt(proc_p);
        end else if (eng_act) begin
            ptr_q <= ptr_q + 1'b1;
            k_q   <= k_q + 1'b1;
            if (store_hit) hcnt_q <= hcnt_q + 1'b1;
        end
    end

    // Frame contents: clear on start, fill hit/charge pairs, header last
    always_ff @(posedge clk) begin
        if (start_job)
            for (int w = 1; w < FRAME_WORDS; w++) frame_q[proc_p][w] <= '0;
        if (store_hit) begin
            frame_q[proc_p][hit_idx]        <= rd_entry.hit;
            frame_q[proc_p][hit_idx + 1'b1] <= rd_entry.chg;
        end
        if (scan_done)
            frame_q[proc_p][0] <= {slot_tag[proc_p], {PAD_W{1'b0}}, hcnt_q};
    end

    // Readout pointer: word index and slot advance on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_p   <= '0;
            rd_idx <= '0;
        end else if (hshake) begin
            if (tx_last) begin
                rd_idx <= '0;
                rd_p   <= nxt(rd_p);
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    assign rd_addr    = ptr_q;
    assign apply_ok   = !eng_act && !any_pend && !trig_in;
    assign busy       = full;
    assign lost_count = lost_q;
    assign tx_data    = frame_q[rd_p][rd_idx];

    // R7
    // busy_drop_chk
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in && busy |=> used_q <= $past(used_q));

    // R7
    // lost_inc_chk
    lost_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in && busy && (lost_count != '1) |=> lost_count == $past(lost_count) + 1'b1);

    // R7
    // occ_bound_chk
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= CNT_W'(NFRAMES));

    // R8
    // tx_hold_chk
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R4
    // hit_cap_chk
    hit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt_q <= HC_W'(MAX_HITS));
endmodule

// File: rtl/trig_window_extractor.sv
// Top level: latency store, control registers and event-frame assembler.
// Assumes one hit per cycle at most, triggers as single-cycle pulses, and
// settings that keep the look-back inside the store depth.
module trig_window_extractor
    import evx_pkg::*;
#(
    parameter int DEPTH_LOG = 8,
    parameter int NFRAMES   = 4,
    parameter int MAX_HITS  = 8,
    parameter int LAT_W     = 6,
    parameter int WIN_W     = 5,
    parameter int TAG_W     = 8,
    parameter int LOST_W    = 16,
    parameter int LAT_RST   = 20,
    parameter int WIN_RST   = 20,
    localparam int CFG_W    = (LAT_W > WIN_W) ? LAT_W : WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [HIT_W-1:0]  hit_word,
    input  logic [HIT_W-1:0]  charge_word,
    input  logic              trig_in,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              busy,
    output logic [LOST_W-1:0] lost_count,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [HIT_W-1:0]  tx_data,
    output logic              tx_last
);
    logic [DEPTH_LOG-1:0] now_ts, rd_addr;
    ring_entry_t          rd_entry;
    logic [LAT_W-1:0]     act_lat;
    logic [WIN_W-1:0]     act_win;
    logic                 apply_ok;

    evx_latency_ring #(.DEPTH_LOG(DEPTH_LOG)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(hit_valid), .wr_hit(hit_word), .wr_chg(charge_word),
        .rd_addr(rd_addr), .now_ts(now_ts), .rd_entry(rd_entry)
    );

    evx_cfg_regs #(
        .LAT_W(LAT_W), .WIN_W(WIN_W), .CFG_W(CFG_W),
        .LAT_RST(LAT_RST), .WIN_RST(WIN_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .apply_ok(apply_ok), .act_lat(act_lat), .act_win(act_win)
    );

    evx_frame_asm #(
        .NFRAMES(NFRAMES), .MAX_HITS(MAX_HITS), .DEPTH_LOG(DEPTH_LOG),
        .LAT_W(LAT_W), .WIN_W(WIN_W), .TAG_W(TAG_W), .LOST_W(LOST_W)
    ) u_asm (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .now_ts(now_ts), .act_lat(act_lat), .act_win(act_win),
        .rd_entry(rd_entry), .rd_addr(rd_addr), .apply_ok(apply_ok),
        .busy(busy), .lost_count(lost_count),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );
endmodule

// File: tb/sim_trig_window_extractor.sv
module sim_trig_window_extractor;
    localparam int NFR = 4;
    localparam int HN  = 1024;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, hit_valid, trig_in, cfg_we, cfg_sel, tx_ready;
    logic        busy, tx_valid, tx_last;
    logic [15:0] hit_word, charge_word, tx_data, lost_count;
    logic [5:0]  cfg_wdata;

    trig_window_extractor u0 (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_word(hit_word),
        .charge_word(charge_word), .trig_in(trig_in), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .busy(busy),
        .lost_count(lost_count), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic        hv [HN];
    logic [15:0] hd [HN];
    logic [15:0] cd [HN];
    int    eT [256], eL [256], eW [256], eTag [256];
    string eReq [256];
    int    qh = 0, qt = 0;
    int    occ = 0, acc = 0, lost_m = 0;
    int    mL = 20, mW = 20, pL = 20, pW = 20;
    logic [15:0] rx [17];
    int    rx_n = 0;
    string req = "R2";
    logic  d_hv = 0, d_trig = 0, d_we = 0, d_sel = 0, d_rdy = 1;
    logic [15:0] d_hit = 0, d_chg = 0;
    logic [5:0]  d_wd = 0;
    logic  s_txv;
    logic [15:0] s_txd, s_lost;
    int    hit_pct = 40, rdy_pct = 100;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(int t, int l, int w, int tag, int idx);
        int n;
        logic [15:0] r;
        n = 0;
        r = 16'h0;
        for (int c = t - l; c < t - l + w; c++) begin
            if (c >= 0 && hv[c % HN]) begin
                if (n < 8) begin
                    if (idx == 1 + 2 * n) r = hd[c % HN];
                    if (idx == 2 + 2 * n) r = cd[c % HN];
                    n++;
                end
            end
        end
        if (idx == 0) r = {tag[7:0], 4'h0, 4'(n)};
        return r;
    endfunction

    task automatic compare_frame();
        int bad;
        logic [15:0] ew;
        bad = -1;
        ew = 0;
        if (qh == qt) begin
            chk(0, "R7 unexpected frame", 0, 1);
            return;
        end
        for (int i = 0; i < 17; i++) begin
            logic [15:0] e;
            e = exp_word(eT[qh % 256], eL[qh % 256], eW[qh % 256], eTag[qh % 256], i);
            if (bad < 0 && rx[i] !== e) begin
                bad = i;
                ew = e;
            end
        end
        if (bad >= 0) chk(0, $sformatf("%s frame tag %0d word %0d", eReq[qh % 256], eTag[qh % 256], bad), rx[bad], ew);
        else          chk(1, eReq[qh % 256], 0, 0);
        qh++;
    endtask

    // One clock cycle: drive, sample, update the reference model
    task automatic step();
        bit apply_now, hs, mbusy;
        @(negedge clk);
        hit_valid = d_hv; hit_word = d_hit; charge_word = d_chg;
        trig_in = d_trig; cfg_we = d_we; cfg_sel = d_sel; cfg_wdata = d_wd;
        tx_ready = d_rdy;
        #1;
        s_txv = tx_valid; s_txd = tx_data; s_lost = lost_count;
        mbusy = (occ == NFR);
        chk(busy === mbusy, "R7 busy", busy, mbusy);
        apply_now = (occ == 0) && !d_trig;
        hs = tx_valid && tx_ready;
        if (hs) begin
            rx[rx_n] = tx_data;
            chk(tx_last === (rx_n == 16), "R8 last flag", tx_last, rx_n == 16);
            rx_n++;
            if (rx_n == 17) begin
                compare_frame();
                rx_n = 0;
                occ--;
            end
        end
        hv[cyc % HN] = d_hv; hd[cyc % HN] = d_hit; cd[cyc % HN] = d_chg;
        if (d_trig) begin
            if (mbusy) lost_m++;
            else begin
                eT[qt % 256] = cyc; eL[qt % 256] = mL; eW[qt % 256] = mW;
                eTag[qt % 256] = acc % 256; eReq[qt % 256] = req;
                qt++; acc++; occ++;
            end
        end
        @(posedge clk);
        cyc++;
        if (apply_now) begin mL = pL; mW = pW; end
        if (d_we) begin
            if (d_sel) pW = d_wd % 32;
            else       pL = d_wd;
        end
        d_trig = 0; d_we = 0;
    endtask

    task automatic rnd_cycle();
        d_hv  = ($urandom % 100) < hit_pct;
        d_hit = 16'($urandom);
        d_chg = 16'($urandom);
        d_rdy = ($urandom % 100) < rdy_pct;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rnd_cycle();
    endtask

    task automatic trig_now();
        d_trig = 1;
        rnd_cycle();
    endtask

    task automatic drain();
        int save;
        save = rdy_pct;
        rdy_pct = 100;
        while (occ != 0) rnd_cycle();
        idle(3);
        rdy_pct = save;
    endtask

    task automatic set_cfg(input int l, input int w);
        d_we = 1; d_sel = 0; d_wd = 6'(l); rnd_cycle();
        d_we = 1; d_sel = 1; d_wd = 6'(w); rnd_cycle();
        idle(3);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        process::self().srandom(32'd1234);
        rst_n = 0; hit_valid = 0; hit_word = 0; charge_word = 0; trig_in = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; tx_ready = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(tx_valid === 1'b0, "R1 tx_valid", tx_valid, 0);
        chk(lost_count === 16'h0, "R1 lost_count", lost_count, 0);
        rst_n = 1;

        // R9 defaults of 20/20, R2 window contents, R3 header and padding
        req = "R9";
        idle(60); trig_now(); idle(5);
        req = "R2";
        idle(30); trig_now(); drain();

        // R5 latency 0 catches the hit in the trigger cycle
        req = "R5";
        set_cfg(0, 1);
        d_hv = 1; d_hit = 16'hA5A5; d_chg = 16'h5A5A; d_trig = 1; d_rdy = 1; step();
        drain();
        // R5 window 0 gives an empty frame
        set_cfg(10, 0);
        idle(20); trig_now(); drain();

        // R4 dense hits overflow the 8-hit cap
        req = "R4";
        set_cfg(20, 20);
        hit_pct = 100;
        idle(30); trig_now(); drain();
        hit_pct = 40;

        // R11 window reaching past the trigger
        req = "R11";
        set_cfg(3, 12);
        hit_pct = 70;
        idle(20); trig_now(); idle(20); drain();

        // R6 overlapping windows 5 cycles apart
        req = "R6";
        set_cfg(20, 20);
        idle(30); trig_now(); idle(4); trig_now(); idle(4); trig_now(); drain();
        hit_pct = 40;

        // R7 busy and lost triggers with a stalled transmitter; R8 stall hold
        req = "R7";
        rdy_pct = 0;
        idle(30);
        for (int i = 0; i < 6; i++) begin trig_now(); idle(4); end
        idle(40);
        chk(busy === 1'b1, "R7 busy after burst", busy, 1);
        rnd_cycle(); held = s_txd;
        rnd_cycle();
        chk(s_txv && s_txd === held, "R8 data held during stall", s_txd, held);
        chk(s_lost === 16'(lost_m), "R7 lost_count", s_lost, lost_m);
        rdy_pct = 100;
        drain();

        // R10 write during assembly does not disturb the frame in flight
        req = "R10";
        set_cfg(10, 10);
        idle(20);
        trig_now();
        d_we = 1; d_sel = 0; d_wd = 6'd30; rnd_cycle();
        d_we = 1; d_sel = 1; d_wd = 6'd4;  rnd_cycle();
        drain();
        idle(35); trig_now(); drain();

        // Random sweep of settings, trigger spacing and back-pressure
        req = "R2";
        for (int it = 0; it < 40; it++) begin
            set_cfg($urandom % 41, $urandom % 32);
            hit_pct = 20 + $urandom % 70;
            rdy_pct = 50 + $urandom % 51;
            idle(45);
            for (int t = 0; t < 6; t++) begin
                trig_now();
                idle(4 + $urandom % 36);
            end
            drain();
        end

        idle(5);
        chk(qh == qt, "R3 all frames delivered", qt - qh, 0);
        chk(s_lost === 16'(lost_m), "R7 final lost_count", s_lost, lost_m);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule